// File: doc/BRIEF.md
# PHY Management Bus Scan and Identification Sequencer

This block walks every address on an Ethernet management bus and finds out which PHYs answer. It does not toggle the serial lines itself. It issues read requests to a separate management frame master, one at a time, through a valid/ready request channel. It takes each read result back on a one-cycle response strobe that carries a data word and an error flag.

For every address whose two identifier registers both read cleanly, the block reads the link-partner ability register once. It then emits one record on a valid/ready output stream. The record holds the address, the 22-bit vendor identifier, the 6-bit model number, the 4-bit revision, a speed flag and a duplex flag.

A single-cycle `start_i` pulse begins a scan. A single-cycle `done_o` pulse closes it once the highest address has been handled. While a record waits for the consumer, the scan holds still.

Top module: `mdscan_seq`

## Requirements
- R1: After reset the block is idle, with `req_valid_o`, `rec_valid_o` and `done_o` all low. It issues no request until `start_i` is pulsed. A scan then visits addresses 0 to 31 once each, in ascending order.
- R2: For each address the reads are issued in this order: register 3, then register 2, then register 5. A request's address and register fields stay stable while `req_valid_o` is high and `req_ready_i` is low.
- R3: If the register 3 read returns `rsp_err_i`=1, the address produces no record and no further reads. If the register 2 read returns `rsp_err_i`=1, the address produces no record and register 5 is not read.
- R4: The identifier is taken from the 32-bit word {reg2, reg3}. The vendor identifier `rec_oui_o` is bits 31:10 of that word, `rec_model_o` is bits 9:4, and `rec_rev_o` is bits 3:0.
- R5: `rec_fast_o` (1 = 100 Mb/s, 0 = 10 Mb/s) is set when bit 7 or bit 8 of register 5 is 1.
- R6: `rec_full_o` (1 = full duplex, 0 = half duplex) is set when bit 6 or bit 8 of register 5 is 1.
- R7: When the register 5 read returns an error, the record is still emitted, with `rec_fast_o`=0 and `rec_full_o`=0, whatever the returned data word holds.
- R8: While `rec_valid_o` is high and `rec_ready_i` is low, every record field stays stable and `req_valid_o` stays low.
- R9: `done_o` is high for exactly one cycle, once per scan, after address 31 has been handled. This holds whether address 31 produced a record or was skipped. The block is idle afterwards.
- R10: A `start_i` pulse that arrives during a scan is ignored. The scan neither restarts nor repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan (pulse) |
| done_o | output | 1 | Scan finished (one-cycle pulse) |
| req_valid_o | output | 1 | Read request to the frame master is valid |
| req_ready_i | input | 1 | Frame master accepts the request |
| req_phy_o | output | 5 | PHY address of the request |
| req_reg_o | output | 5 | Register number of the request |
| rsp_valid_i | input | 1 | Read result strobe |
| rsp_err_i | input | 1 | Read failed (no turnaround answer) |
| rsp_data_i | input | 16 | Read data |
| rec_valid_o | output | 1 | Discovery record valid |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_addr_o | output | 5 | Address of the discovered PHY |
| rec_oui_o | output | 22 | Vendor identifier |
| rec_model_o | output | 6 | Model number |
| rec_rev_o | output | 4 | Revision number |
| rec_fast_o | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| rec_full_o | output | 1 | 1 = full duplex, 0 = half duplex |

## Verification
The bench scores every accepted request against an expected address and register sequence. A design that read register 2 before register 3, or kept reading after an identifier error, would therefore break the sequence at once. Register 5 values light bits 6, 7 and 8 one at a time, plus a value with every other bit set. A design with a wrong bit position, or one that swapped the 10 Mb/s full-duplex flag for the 100 Mb/s one, would produce wrong flags. A failing register 5 read returns a data word with all three ability bits set, so a design that ignored the error would report 100 Mb/s full duplex. Further scans throttle the consumer and the request side, leave address 31 silent, and pulse start mid-scan. These catch records that change while stalled, a missing done when the last address is skipped, and a scan that restarts.

// File: rtl/mdscan_pkg.sv
package mdscan_pkg;

    localparam int MD_DW = 16;

    // register numbers on the management bus
    localparam logic [4:0] REG_ID_HI = 5'd2;
    localparam logic [4:0] REG_ID_LO = 5'd3;
    localparam logic [4:0] REG_ABIL  = 5'd5;

    // ability bit positions in register 5 (contiguous, lowest first)
    localparam int ABIL_10FD = 6;
    localparam int ABIL_TXHD = 7;
    localparam int ABIL_TXFD = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_WAIT,
        ST_EMIT,
        ST_DONE
    } scan_st_e;

    typedef enum logic [1:0] {
        RD_ID_LO,
        RD_ID_HI,
        RD_ABIL
    } rd_step_e;

    typedef struct packed {
        logic [21:0] oui;
        logic [5:0]  model;
        logic [3:0]  rev;
    } phy_id_t;

    typedef struct packed {
        logic fast;
        logic full;
    } link_mode_t;

    function automatic phy_id_t split_id(input logic [MD_DW-1:0] hi,
                                         input logic [MD_DW-1:0] lo);
        logic [2*MD_DW-1:0] w;
        phy_id_t r;
        w       = {hi, lo};
        r.oui   = w[31:10];
        r.model = w[9:4];
        r.rev   = w[3:0];
        return r;
    endfunction

    // bits: [2]=100 full, [1]=100 half, [0]=10 full
    function automatic link_mode_t decode_abil(input logic [2:0] b,
                                               input logic fail);
        link_mode_t m;
        m.fast = !fail && (b[2] || b[1]);
        m.full = !fail && (b[2] || b[0]);
        return m;
    endfunction

endpackage

// File: rtl/mdscan_idcap.sv
module mdscan_idcap
    import mdscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_lo,
    input  logic             cap_hi,
    input  logic [MD_DW-1:0] word,
    output phy_id_t          id
);
    logic [MD_DW-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= word;
            if (cap_hi) hi_q <= word;
        end
    end

    assign id = split_id(hi_q, lo_q);

    // R4: the upper half of the vendor identifier follows the reg2 capture
    p_hi_capture_r4: assert property (@(posedge clk) disable iff (rst)
        cap_hi |=> id.oui[21:6] == $past(word));

endmodule

// File: rtl/mdscan_linkdec.sv
module mdscan_linkdec
    import mdscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap,
    input  logic       fail,
    input  logic [2:0] abil_bits,
    output link_mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst) mode <= '0;
        else if (cap) mode <= decode_abil(abil_bits, fail);
    end

    // R7: a failed ability read falls back to 10 Mb/s half duplex
    p_fallback_r7: assert property (@(posedge clk) disable iff (rst)
        (cap && fail) |=> (!mode.fast && !mode.full));

endmodule

// File: rtl/mdscan_seq.sv
module mdscan_seq
    import mdscan_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              done_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_phy_o,
    output logic [4:0]        req_reg_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_err_i,
    input  logic [MD_DW-1:0]  rsp_data_i,
    output logic              rec_valid_o,
    input  logic              rec_ready_i,
    output logic [ADDR_W-1:0] rec_addr_o,
    output logic [21:0]       rec_oui_o,
    output logic [5:0]        rec_model_o,
    output logic [3:0]        rec_rev_o,
    output logic              rec_fast_o,
    output logic              rec_full_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    scan_st_e          st;
    rd_step_e          step;
    logic [ADDR_W-1:0] addr;
    logic              got, adv, cap_lo, cap_hi, cap_ab;
    phy_id_t           id;
    link_mode_t        mode;

    assign got    = (st == ST_WAIT) && rsp_valid_i;
    assign cap_lo = got && !rsp_err_i && (step == RD_ID_LO);
    assign cap_hi = got && !rsp_err_i && (step == RD_ID_HI);
    assign cap_ab = got && (step == RD_ABIL);
    assign adv    = (got && rsp_err_i && (step != RD_ABIL)) ||
                    ((st == ST_EMIT) && rec_ready_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            addr <= '0;
            step <= RD_ID_LO;
        end else if (adv) begin
            if (addr == LAST_ADDR) begin
                st <= ST_DONE;
            end else begin
                addr <= addr + 1'b1;
                step <= RD_ID_LO;
                st   <= ST_ASK;
            end
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    addr <= '0;
                    step <= RD_ID_LO;
                    st   <= ST_ASK;
                end
                ST_ASK:  if (req_ready_i) st <= ST_WAIT;
                ST_WAIT: if (rsp_valid_i) begin
                    if (step == RD_ABIL) begin
                        st <= ST_EMIT;
                    end else begin
                        step <= (step == RD_ID_LO) ? RD_ID_HI : RD_ABIL;
                        st   <= ST_ASK;
                    end
                end
                ST_EMIT: ;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (step)
            RD_ID_LO: req_reg_o = REG_ID_LO;
            RD_ID_HI: req_reg_o = REG_ID_HI;
            default:  req_reg_o = REG_ABIL;
        endcase
    end

    mdscan_idcap u_idcap (
        .clk    (clk),
        .rst    (rst),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .word   (rsp_data_i),
        .id     (id)
    );

    mdscan_linkdec u_link (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap_ab),
        .fail      (rsp_err_i),
        .abil_bits (rsp_data_i[ABIL_TXFD:ABIL_10FD]),
        .mode      (mode)
    );

    assign req_valid_o = (st == ST_ASK);
    assign req_phy_o   = addr;
    assign rec_valid_o = (st == ST_EMIT);
    assign rec_addr_o  = addr;
    assign rec_oui_o   = id.oui;
    assign rec_model_o = id.model;
    assign rec_rev_o   = id.rev;
    assign rec_fast_o  = mode.fast;
    assign rec_full_o  = mode.full;
    assign done_o      = (st == ST_DONE);

    // R2: request fields hold until the frame master takes them
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_phy_o) && $stable(req_reg_o)));

    // R2: the first request at a fresh address reads register 3
    p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && (req_phy_o != $past(req_phy_o))) |->
            (req_reg_o == REG_ID_LO));

    // R8: a stalled record does not move
    p_rec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && !rec_ready_i) |=>
            (rec_valid_o && $stable(rec_addr_o) && $stable(rec_oui_o) &&
             $stable(rec_model_o) && $stable(rec_rev_o) &&
             $stable(rec_fast_o) && $stable(rec_full_o)));

    // R8: no bus traffic while a record is pending
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |-> !req_valid_o);

    // R9: done is a single-cycle pulse, raised at the top address
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_last_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (req_phy_o == LAST_ADDR && !req_valid_o));

endmodule

// File: tb/sim_mdscan_seq.sv
module sim_mdscan_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        done_o;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [4:0]  req_phy_o;
    logic [4:0]  req_reg_o;
    logic        rsp_valid_i = 1'b0;
    logic        rsp_err_i = 1'b0;
    logic [15:0] rsp_data_i = '0;
    logic        rec_valid_o;
    logic        rec_ready_i = 1'b0;
    logic [4:0]  rec_addr_o;
    logic [21:0] rec_oui_o;
    logic [5:0]  rec_model_o;
    logic [3:0]  rec_rev_o;
    logic        rec_fast_o;
    logic        rec_full_o;

    always #4 clk = ~clk;

    mdscan_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_phy_o(req_phy_o), .req_reg_o(req_reg_o),
        .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_data_i(rsp_data_i),
        .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
        .rec_addr_o(rec_addr_o), .rec_oui_o(rec_oui_o), .rec_model_o(rec_model_o),
        .rec_rev_o(rec_rev_o), .rec_fast_o(rec_fast_o), .rec_full_o(rec_full_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int scan_id = 0;
    bit live = 0;
    bit rec_throttle = 0;
    bit req_throttle = 0;
    int cyc = 0;
    int done_cnt = 0;
    bit prev_done = 0;
    int rsp_cnt = 0;
    logic [4:0] lat_phy, lat_reg;
    bit held_ok = 0;
    logic [38:0] held_rec;

    logic [9:0]  exp_req[$];
    logic [38:0] exp_rec[$];

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit present(input int s, input int a);
        if (s == 1) return (a == 3 || a == 5 || a == 6 || a == 13);
        return (a == 0 || a == 3 || a == 5 || a == 6 || a == 13 || a == 31);
    endfunction
    function automatic logic [15:0] r2v(input int a);
        return 16'h1000 + 16'(a) * 16'h0421;
    endfunction
    function automatic logic [15:0] r3v(input int a);
        return 16'hA5C0 ^ (16'(a) * 16'h0B17);
    endfunction
    function automatic logic [15:0] r5v(input int a);
        case (a)
            0:       return 16'h0080;
            3:       return 16'hFE3F;
            5:       return 16'h0040;
            31:      return 16'h0100;
            default: return 16'h0180;
        endcase
    endfunction

    function automatic logic [38:0] cur_rec();
        return {rec_addr_o, rec_oui_o, rec_model_o, rec_rev_o, rec_fast_o, rec_full_o};
    endfunction

    // driver side: expected request and record queues for one scan
    task automatic plan_scan(input int s);
        exp_req.delete();
        exp_rec.delete();
        for (int a = 0; a < 32; a++) begin
            exp_req.push_back({5'(a), 5'd3});
            if (!present(s, a)) continue;                    // R3
            exp_req.push_back({5'(a), 5'd2});
            if (a == 6) continue;                            // R3
            exp_req.push_back({5'(a), 5'd5});
            begin
                logic [31:0] w;
                logic [15:0] ab;
                logic fast, full;
                w  = {r2v(a), r3v(a)};                       // R4
                ab = r5v(a);
                fast = (a == 13) ? 1'b0 : (ab[7] | ab[8]);   // R5, R7
                full = (a == 13) ? 1'b0 : (ab[6] | ab[8]);   // R6, R7
                exp_rec.push_back({5'(a), w[31:10], w[9:4], w[3:0], fast, full});
            end
        end
    endtask

    // monitor / responder
    always @(negedge clk) begin
        if (live) begin
            cyc++;
            req_ready_i = req_throttle ? (cyc % 3 != 0) : 1'b1;
            rec_ready_i = rec_throttle ? (cyc % 4 == 3) : 1'b1;

            rsp_valid_i = 1'b0;
            if (rsp_cnt != 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid_i = 1'b1;
                    case (lat_reg)
                        5'd3: begin rsp_err_i = !present(scan_id, lat_phy); rsp_data_i = r3v(lat_phy); end
                        5'd2: begin rsp_err_i = (lat_phy == 5'd6); rsp_data_i = r2v(lat_phy); end
                        default: begin
                            rsp_err_i  = (lat_phy == 5'd13);
                            rsp_data_i = (lat_phy == 5'd13) ? 16'h01C0 : r5v(lat_phy);
                        end
                    endcase
                end
            end

            if (req_valid_o && req_ready_i) begin
                if (exp_req.size() == 0) begin
                    chk(0, "R1 extra request", {54'd0, req_phy_o, req_reg_o}, 64'd0);
                end else begin
                    logic [9:0] e;
                    e = exp_req.pop_front();
                    chk({req_phy_o, req_reg_o} == e, "R2 request address/register order",
                        {54'd0, req_phy_o, req_reg_o}, {54'd0, e});
                end
                lat_phy = req_phy_o;
                lat_reg = req_reg_o;
                rsp_cnt = 2;
            end

            if (rec_valid_o) begin
                if (held_ok)
                    chk(cur_rec() == held_rec, "R8 record stable while stalled",
                        {25'd0, cur_rec()}, {25'd0, held_rec});
                if (rec_ready_i) begin
                    held_ok = 0;
                    if (exp_rec.size() == 0) begin
                        chk(0, "R3 unexpected record", {25'd0, cur_rec()}, 64'd0);
                    end else begin
                        logic [38:0] e;
                        e = exp_rec.pop_front();
                        chk(cur_rec() == e, "R4 R5 R6 R7 record fields",
                            {25'd0, cur_rec()}, {25'd0, e});
                    end
                end else begin
                    held_ok  = 1;
                    held_rec = cur_rec();
                    chk(!req_valid_o, "R8 no request while record pending",
                        {63'd0, req_valid_o}, 64'd0);
                end
            end

            if (done_o) done_cnt++;
            if (done_o && prev_done)
                chk(0, "R9 done wider than one cycle", 64'd2, 64'd1);
            prev_done = done_o;
        end
    end

    task automatic run_scan(input int s, input bit mid_start);
        scan_id = s;
        plan_scan(s);
        done_cnt = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (mid_start) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;                                  // R10
            @(negedge clk); start_i = 1'b0;
        end
        for (int k = 0; k < 20000 && done_cnt == 0; k++) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(done_cnt == 1, "R9 one done pulse per scan", 64'(done_cnt), 64'd1);
        chk(exp_req.size() == 0, "R1 all addresses visited", 64'(exp_req.size()), 64'd0);
        chk(exp_rec.size() == 0, "R10 records complete, no restart", 64'(exp_rec.size()), 64'd0);
        chk(!req_valid_o && !rec_valid_o, "R9 idle after done",
            {62'd0, req_valid_o, rec_valid_o}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_valid_o && !rec_valid_o && !done_o, "R1 reset state",
            {61'd0, req_valid_o, rec_valid_o, done_o}, 64'd0);
        live = 1;
        repeat (20) @(negedge clk);
        chk(!req_valid_o, "R1 no request without start", {63'd0, req_valid_o}, 64'd0);

        run_scan(0, 0);
        rec_throttle = 1; req_throttle = 1;
        run_scan(1, 0);
        run_scan(0, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule